// File: doc/BRIEF.md
# Maskable Interrupt Controller with Acceptance Sequencer

The block gathers interrupt events from eleven sources. Eight are one-cycle event pulses from on-chip peripherals. Three come from external pins, each with its own selectable edge sensitivity. Every event sets a latched request flag. Each flag is qualified by its own enable bit. The enabled set is then qualified by a global mask bit taken from the processor status byte. The request and enable bits are held in four byte-wide registers on a simple address/data register bus, and software can read and write all of them.

When the processor signals an instruction boundary and an enabled request is pending, the block takes the highest-priority source and runs a fixed eight-cycle acceptance sequence:

1. It pulses a strobe telling the core to drop the global mask.
2. It clears the accepted request flag.
3. It writes the return address (high byte, then low byte) and the status byte to a byte-wide stack, at descending addresses.
4. It presents the source's 16-bit entry address together with a load strobe for the program counter.

The core, the vector table contents and the peripherals that raise the events lie outside the block.

Top module: `irq_accept_ctrl`

## Requirements
- R1: Each external pin has a 2-bit mode field in `ext_mode` (pin k uses bits 2k+1:2k): 00 ignores the pin, 01 sets the flag on a 1-to-0 change, 10 sets it on a 0-to-1 change, and 11 sets it on either change. The flag is visible on the register bus one cycle after the change.
- R2: A one-cycle pulse on `periph_evt[j]` sets its flag. The mapping is j=0 key-scan, 1 basic timer, 2 timer 0, 3 timer 1, 4 remote, 5 ADC, 6 serial, 7 watch timer.
- R3: The register map is as follows. Request-high is at 0xDD and request-low at 0xDC. Enable-high is at 0xDB and enable-low at 0xDA. The high registers hold bit6 key-scan, bit5 basic timer, bit4 ext0, bit3 ext1, bit2 timer 0, bit1 timer 1, bit0 ext2. The low registers hold bit6 remote, bit5 ADC, bit4 serial, bit3 watch timer. Unused bits read 0, and every register resets to 0.
- R4: A request flag stays set until software writes it, the sequence accepts it, or reset clears it. A bus write can both set and clear flags.
- R5: A sequence starts only in a cycle where `insn_done` is 1, `psw_in[2]` is 1, and at least one flag with its enable bit set is pending.
- R6: Among pending enabled sources, the one that wins is first in this order: key-scan, basic timer, ext0, ext1, timer 0, timer 1, ext2, remote, ADC, serial, watch timer.
- R7: The sequence takes eight cycles, counted from the cycle after the start. In cycle 1 `mie_clr` pulses. At the end of cycle 2 the accepted flag is cleared. Cycles 3, 4 and 5 write the PC high byte, the PC low byte and the captured status byte to addresses SP, SP-1 and SP-2. In cycle 8 `vec_load` pulses. `busy` is high for exactly those eight cycles.
- R8: The entry address in the `vec_load` cycle is 0xFFE0 minus twice the winner's position in the R6 order (key-scan 0xFFE0, watch timer 0xFFCC).
- R9: If a source event arrives in the same cycle that the sequence clears that source's flag, the flag ends up set.
- R10: While a sequence runs, `insn_done` and newly pending requests are ignored. PC, SP and status are taken as captured at the start, and the vector belongs to the source picked at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 3 | External interrupt pins ext0, ext1, ext2 |
| ext_mode | input | 6 | Edge mode, two bits per pin |
| periph_evt | input | 8 | One-cycle peripheral event pulses |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| insn_done | input | 1 | Current instruction has completed |
| psw_in | input | 8 | Processor status byte, bit 2 is the global mask |
| pc_in | input | 16 | Return address to save |
| sp_in | input | 8 | Current stack pointer |
| busy | output | 1 | Acceptance sequence running |
| mie_clr | output | 1 | Strobe telling the core to clear the global mask |
| stk_we | output | 1 | Stack write enable |
| stk_addr | output | 8 | Stack write address |
| stk_data | output | 8 | Stack write data |
| vec_load | output | 1 | Load strobe for the program counter |
| vec_addr | output | 16 | Service routine entry address |

## Verification
The hardest case to reach from the ports is an external edge that lands exactly in the cycle where the sequence clears that same source's flag. The bench starts an acceptance of ext0 with the pin held high in falling-edge mode. It counts negative clock edges from the start cycle and drops the pin in the second sequence cycle. It then reads the request register while the pushes run and expects the bit still set. A second hard case is a higher-priority request that appears mid-sequence while `insn_done` is held high. The bench checks that the vector still belongs to the source captured at the start and that no second mask strobe appears.

// File: rtl/irq_pkg.sv
// Package: shared constants, register addresses, source ordering helpers and
// the state encoding of the acceptance sequencer.
package irq_pkg;
    localparam int SRC_CNT  = 11;   // sources, index = priority (0 wins)
    localparam int EXT_CNT  = 3;    // external edge pins
    localparam int PER_CNT  = 8;    // peripheral pulse inputs
    localparam int HI_CNT   = 7;    // sources held in the high registers

    localparam logic [7:0] A_ENL = 8'hDA;
    localparam logic [7:0] A_ENH = 8'hDB;
    localparam logic [7:0] A_RQL = 8'hDC;
    localparam logic [7:0] A_RQH = 8'hDD;

    typedef enum logic [1:0] {
        EM_OFF  = 2'b00,
        EM_FALL = 2'b01,
        EM_RISE = 2'b10,
        EM_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_MASK, SQ_CLR, SQ_PCH, SQ_PCL, SQ_PSW,
        SQ_WAIT0, SQ_WAIT1, SQ_VEC
    } seq_e;

    // True when source i lives in the high register pair.
    function automatic logic src_hi(input int i);
        return i < HI_CNT;
    endfunction

    // Bit position of source i inside its register.
    function automatic int src_pos(input int i);
        return (i < HI_CNT) ? (6 - i) : (6 + HI_CNT - i);
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
// Edge detector: one instance per external pin (generate), each flags a
// 1-to-0, 0-to-1 or any change according to its 2-bit mode.
// Assumes pins are already synchronous to clk.
module irq_edge_det
    import irq_pkg::*;
#(
    parameter int NPIN = EXT_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin,
    input  logic [2*NPIN-1:0] mode,
    output logic [NPIN-1:0]   edge_o
);
    logic [NPIN-1:0] prev_q;

    // Remember last pin level; reset loads the live level so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= pin;
        else        prev_q <= pin;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        edge_mode_e m;
        assign m = edge_mode_e'(mode[2*g +: 2]);

        // Select the edge polarity this pin reacts to.
        always_comb begin
            unique case (m)
                EM_FALL: edge_o[g] = prev_q[g] & ~pin[g];
                EM_RISE: edge_o[g] = ~prev_q[g] & pin[g];
                EM_BOTH: edge_o[g] = prev_q[g] ^ pin[g];
                default: edge_o[g] = 1'b0;
            endcase
        end

        p_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (m == EM_FALL && $fell(pin[g])) |-> edge_o[g]);
        p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(pin[g]) || m == EM_OFF) |-> !edge_o[g]);
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Flag bank: request flags and enable bits, their register-bus view, and the
// fixed-priority pick of the pending enabled source.
// Assumes set_vec is ordered by priority; a set beats a clear in one cycle.
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int NSRC = SRC_CNT,
    parameter int IW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic            pend_any,
    output logic [IW-1:0]   pend_idx
);
    logic [NSRC-1:0] flags_q, flags_nx, en_q, en_nx, pend, lowmask, clr_mask;

    // Next flag/enable values: bus write, then hardware clear, then set.
    always_comb begin
        flags_nx = flags_q;
        en_nx    = en_q;
        for (int i = 0; i < NSRC; i++) begin
            if (bus_wr && bus_addr == (src_hi(i) ? A_RQH : A_RQL))
                flags_nx[i] = bus_wdata[src_pos(i)];
            if (bus_wr && bus_addr == (src_hi(i) ? A_ENH : A_ENL))
                en_nx[i] = bus_wdata[src_pos(i)];
            if (clr_en && clr_idx == IW'(i))
                flags_nx[i] = 1'b0;
            if (set_vec[i])
                flags_nx[i] = 1'b1;
        end
    end

    // Register the flags and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= flags_nx;
            en_q    <= en_nx;
        end
    end

    // Read mux; unused bit positions stay 0.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (bus_addr == (src_hi(i) ? A_RQH : A_RQL))
                bus_rdata[src_pos(i)] = flags_q[i];
            if (bus_addr == (src_hi(i) ? A_ENH : A_ENL))
                bus_rdata[src_pos(i)] = en_q[i];
        end
    end

    // Fixed priority: lowest index among enabled pending sources.
    always_comb begin
        pend     = flags_q & en_q;
        pend_any = |pend;
        pend_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (pend[i]) pend_idx = IW'(i);
    end

    assign lowmask  = (NSRC'(1) << pend_idx) - NSRC'(1);
    assign clr_mask = NSRC'(1) << clr_idx;

    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |-> (pend[pend_idx] && (pend & lowmask) == '0));
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !bus_wr && (set_vec & clr_mask) == '0)
        |=> ((flags_q & $past(clr_mask)) == '0));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !clr_en && set_vec == '0) |=> (flags_q == $past(flags_q)));
endmodule

// File: rtl/irq_seq.sv
// Acceptance sequencer: on an instruction boundary with an enabled pending
// request and the global mask set, captures winner/PC/SP/status and runs the
// eight-cycle mask, clear, push x3, wait x2, vector-load sequence.
// Assumes the core applies mie_clr and vec_load and adjusts SP itself.
module irq_seq
    import irq_pkg::*;
#(
    parameter int          IW       = 4,
    parameter logic [15:0] VEC_BASE = 16'hFFE0,
    parameter int          MIE_BIT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_done,
    input  logic [7:0]    psw_in,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    sp_in,
    input  logic          pend_any,
    input  logic [IW-1:0] pend_idx,
    output logic          busy,
    output logic          mie_clr,
    output logic          clr_en,
    output logic [IW-1:0] clr_idx,
    output logic          stk_we,
    output logic [7:0]    stk_addr,
    output logic [7:0]    stk_data,
    output logic          vec_load,
    output logic [15:0]   vec_addr
);
    seq_e          state_q;
    logic          start;
    logic [IW-1:0] win_q;
    logic [15:0]   pc_q;
    logic [7:0]    psw_q, sp_q;

    assign start = (state_q == SQ_IDLE) && insn_done && psw_in[MIE_BIT] && pend_any;

    // Step the sequence; VEC returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 state_q <= SQ_IDLE;
        else if (state_q == SQ_IDLE) state_q <= start ? SQ_MASK : SQ_IDLE;
        else if (state_q == SQ_VEC)  state_q <= SQ_IDLE;
        else                        state_q <= seq_e'(state_q + 4'd1);
    end

    // Capture the winner and the context at the start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0; pc_q <= '0; psw_q <= '0; sp_q <= '0;
        end else if (start) begin
            win_q <= pend_idx; pc_q <= pc_in; psw_q <= psw_in; sp_q <= sp_in;
        end
    end

    // Per-step strobes and stack port.
    always_comb begin
        busy     = (state_q != SQ_IDLE);
        mie_clr  = (state_q == SQ_MASK);
        clr_en   = (state_q == SQ_CLR);
        clr_idx  = win_q;
        vec_load = (state_q == SQ_VEC);
        vec_addr = VEC_BASE - {{(15 - IW){1'b0}}, win_q, 1'b0};
        stk_we   = 1'b0;
        stk_addr = sp_q;
        stk_data = '0;
        case (state_q)
            SQ_PCH: begin stk_we = 1'b1; stk_addr = sp_q;        stk_data = pc_q[15:8]; end
            SQ_PCL: begin stk_we = 1'b1; stk_addr = sp_q - 8'd1; stk_data = pc_q[7:0];  end
            SQ_PSW: begin stk_we = 1'b1; stk_addr = sp_q - 8'd2; stk_data = psw_q;      end
            default: ;
        endcase
    end

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done && psw_in[MIE_BIT] && pend_any));
    p_mask_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mie_clr);
    p_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mie_clr, clr_en, stk_we, vec_load}));
    p_push_after_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_we) |-> $past(clr_en));
    p_stk_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - 8'd1));
    p_vec_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> !busy);
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vec_load) |=> (busy && !$rose(mie_clr) || vec_load));
endmodule

// File: rtl/irq_accept_ctrl.sv
// Top: maps peripheral pulses and pin edges onto the priority-ordered source
// vector, and connects the flag bank and the acceptance sequencer.
// Assumes all inputs are synchronous to clk.
module irq_accept_ctrl
    import irq_pkg::*;
#(
    parameter logic [15:0] VEC_BASE = 16'hFFE0,
    parameter int          MIE_BIT  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EXT_CNT-1:0]   ext_pin,
    input  logic [2*EXT_CNT-1:0] ext_mode,
    input  logic [PER_CNT-1:0]   periph_evt,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 insn_done,
    input  logic [7:0]           psw_in,
    input  logic [15:0]          pc_in,
    input  logic [7:0]           sp_in,
    output logic                 busy,
    output logic                 mie_clr,
    output logic                 stk_we,
    output logic [7:0]           stk_addr,
    output logic [7:0]           stk_data,
    output logic                 vec_load,
    output logic [15:0]          vec_addr
);
    localparam int IW = $clog2(SRC_CNT);

    logic [EXT_CNT-1:0] ext_edge;
    logic [SRC_CNT-1:0] set_vec;
    logic               clr_en, pend_any;
    logic [IW-1:0]      clr_idx, pend_idx;

    irq_edge_det #(.NPIN(EXT_CNT)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .mode(ext_mode), .edge_o(ext_edge)
    );

    // Place every event at its priority index.
    always_comb begin
        set_vec     = '0;
        set_vec[0]  = periph_evt[0];  // key-scan
        set_vec[1]  = periph_evt[1];  // basic timer
        set_vec[2]  = ext_edge[0];
        set_vec[3]  = ext_edge[1];
        set_vec[4]  = periph_evt[2];  // timer 0
        set_vec[5]  = periph_evt[3];  // timer 1
        set_vec[6]  = ext_edge[2];
        set_vec[7]  = periph_evt[4];  // remote
        set_vec[8]  = periph_evt[5];  // ADC
        set_vec[9]  = periph_evt[6];  // serial
        set_vec[10] = periph_evt[7];  // watch timer
    end

    irq_flag_bank #(.NSRC(SRC_CNT), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pend_any(pend_any), .pend_idx(pend_idx)
    );

    irq_seq #(.IW(IW), .VEC_BASE(VEC_BASE), .MIE_BIT(MIE_BIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .psw_in(psw_in),
        .pc_in(pc_in), .sp_in(sp_in), .pend_any(pend_any), .pend_idx(pend_idx),
        .busy(busy), .mie_clr(mie_clr), .clr_en(clr_en), .clr_idx(clr_idx),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data),
        .vec_load(vec_load), .vec_addr(vec_addr)
    );
endmodule

// File: tb/sim_irq_accept_ctrl.sv
module sim_irq_accept_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_pin = '0;
    logic [5:0]  ext_mode = '0;
    logic [7:0]  periph_evt = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        insn_done = 1'b0;
    logic [7:0]  psw_in = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic        busy, mie_clr, stk_we, vec_load;
    logic [7:0]  stk_addr, stk_data;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_accept_ctrl u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic clear_all();
        wr(8'hDD, 8'h00); wr(8'hDC, 8'h00); wr(8'hDB, 8'h00); wr(8'hDA, 8'h00);
    endtask

    function automatic logic [7:0] addr_of(input int idx);
        return (idx < 7) ? 8'hDD : 8'hDC;
    endfunction
    function automatic int pos_of(input int idx);
        return (idx < 7) ? 6 - idx : 13 - idx;
    endfunction

    // Runs one acceptance from an idle bench; coinc drops ext0 in the clear cycle.
    task automatic accept(input int idx, input logic [15:0] pc, input logic [7:0] psw,
                          input logic [7:0] sp, input bit hold_done, input bit coinc);
        logic [7:0] d;
        @(negedge clk);
        pc_in = pc; psw_in = psw; sp_in = sp; insn_done = 1'b1;
        @(negedge clk);                                   // cycle 1
        if (!hold_done) insn_done = 1'b0;
        chk(mie_clr && busy, "R7 mask strobe cycle 1", {busy, mie_clr}, 2'b11);
        pc_in = ~pc; sp_in = ~sp; psw_in = ~psw | 8'h04;   // R10: later inputs ignored
        if (hold_done) wr_pulse_key();
        @(negedge clk);                                   // cycle 2
        chk(!stk_we && !mie_clr, "R7 cycle 2 quiet", stk_we, 0);
        if (coinc) ext_pin[0] = 1'b0;
        @(negedge clk);                                   // cycle 3
        rd(addr_of(idx), d);
        chk(d[pos_of(idx)] == coinc, coinc ? "R9 flag re-set" : "R7 flag cleared",
            d[pos_of(idx)], coinc);
        chk(stk_we && stk_addr == sp && stk_data == pc[15:8], "R7 push PC high",
            {stk_we, stk_addr, stk_data}, {1'b1, sp, pc[15:8]});
        @(negedge clk);                                   // cycle 4
        chk(stk_we && stk_addr == sp - 8'd1 && stk_data == pc[7:0], "R7 push PC low",
            {stk_we, stk_addr, stk_data}, {1'b1, sp - 8'd1, pc[7:0]});
        @(negedge clk);                                   // cycle 5
        chk(stk_we && stk_addr == sp - 8'd2 && stk_data == psw, "R7 push status",
            {stk_we, stk_addr, stk_data}, {1'b1, sp - 8'd2, psw});
        @(negedge clk);                                   // cycle 6
        @(negedge clk);                                   // cycle 7
        chk(!stk_we && !vec_load && busy && !mie_clr, "R10 wait cycles quiet",
            {stk_we, vec_load, busy, mie_clr}, 4'b0010);
        @(negedge clk);                                   // cycle 8
        insn_done = 1'b0;
        chk(vec_load && vec_addr == 16'hFFE0 - 16'(2 * idx), "R8 vector load",
            {vec_load, vec_addr}, {1'b1, 16'hFFE0 - 16'(2 * idx)});
        @(negedge clk);
        chk(!busy && !vec_load, "R7 sequence is eight cycles", busy, 0);
    endtask

    // Raises a key-scan event during a running sequence.
    task automatic wr_pulse_key();
        periph_evt[0] = 1'b1;
        @(posedge clk);
        #1 periph_evt[0] = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        rd(8'hDD, d); chk(d == 0, "R3 reset request-high", d, 0);
        rd(8'hDC, d); chk(d == 0, "R3 reset request-low", d, 0);
        rd(8'hDB, d); chk(d == 0, "R3 reset enable-high", d, 0);
        rd(8'hDA, d); chk(d == 0, "R3 reset enable-low", d, 0);
        chk(!busy && !stk_we && !vec_load && !mie_clr, "R7 idle after reset", busy, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(8'hDB, 8'hFF); rd(8'hDB, d); chk(d == 8'h7F, "R3 enable-high mask", d, 8'h7F);
        wr(8'hDA, 8'hFF); rd(8'hDA, d); chk(d == 8'h78, "R3 enable-low mask", d, 8'h78);
        wr(8'hDD, 8'h55); rd(8'hDD, d); chk(d == 8'h55, "R4 request write set", d, 8'h55);
        wr(8'hDC, 8'hFF); rd(8'hDC, d); chk(d == 8'h78, "R3 request-low mask", d, 8'h78);
        wr(8'hDD, 8'h14); rd(8'hDD, d); chk(d == 8'h14, "R4 request write clear", d, 8'h14);
        clear_all();
    endtask

    task automatic t_periph();
        logic [7:0] d;
        @(negedge clk); periph_evt = 8'b1000_0010;      // basic timer, watch timer
        @(negedge clk); periph_evt = '0;
        rd(8'hDD, d); chk(d == 8'h20, "R2 basic timer flag", d, 8'h20);
        rd(8'hDC, d); chk(d == 8'h08, "R2 watch timer flag", d, 8'h08);
        repeat (5) @(negedge clk);
        rd(8'hDD, d); chk(d == 8'h20, "R4 flag holds", d, 8'h20);
        clear_all();
    endtask

    task automatic t_edges();
        logic [7:0] d;
        ext_mode = {2'b11, 2'b10, 2'b01};               // ext2 both, ext1 rise, ext0 fall
        @(negedge clk); ext_pin = 3'b111;
        @(negedge clk);
        rd(8'hDD, d); chk(d == 8'h09, "R1 rising pattern", d, 8'h09);
        clear_all();
        @(negedge clk); ext_pin = 3'b000;
        @(negedge clk);
        rd(8'hDD, d); chk(d == 8'h11, "R1 falling pattern", d, 8'h11);
        clear_all();
        ext_mode = 6'b00_00_00;
        @(negedge clk); ext_pin = 3'b111;
        @(negedge clk); ext_pin = 3'b000;
        @(negedge clk);
        rd(8'hDD, d); chk(d == 8'h00, "R1 mode off ignores pins", d, 0);
        clear_all();
    endtask

    task automatic t_gate();
        wr(8'hDD, 8'h40);                                // key-scan pending, not enabled
        @(negedge clk); psw_in = 8'h04; insn_done = 1'b1;
        @(negedge clk); chk(!busy, "R5 no start without enable", busy, 0);
        insn_done = 1'b0;
        wr(8'hDB, 8'h40);
        @(negedge clk); psw_in = 8'h00; insn_done = 1'b1;
        @(negedge clk); chk(!busy, "R5 no start with mask clear", busy, 0);
        insn_done = 1'b0; psw_in = 8'h04;
        repeat (3) @(negedge clk);
        chk(!busy, "R5 no start between instructions", busy, 0);
        accept(0, 16'h1234, 8'h86, 8'hF0, 0, 0);
        clear_all();
    endtask

    task automatic t_prio();
        wr(8'hDB, 8'h7F); wr(8'hDA, 8'h78);
        wr(8'hDD, 8'h05); wr(8'hDC, 8'h10);              // timer0, ext2, serial
        accept(4, 16'hA55A, 8'h04, 8'hC0, 0, 0);
        accept(6, 16'h0102, 8'h24, 8'hBD, 0, 0);
        accept(9, 16'hFEDC, 8'hC4, 8'h03, 0, 0);
        clear_all();
    endtask

    task automatic t_coinc();
        ext_mode = 6'b00_00_01;
        @(negedge clk); ext_pin = 3'b001;                // high, no falling edge
        wr(8'hDD, 8'h00);
        wr(8'hDD, 8'h10); wr(8'hDB, 8'h10);
        accept(2, 16'h4321, 8'h04, 8'h80, 0, 1);
        clear_all();
        ext_mode = '0;
    endtask

    task automatic t_busy();
        logic [7:0] d;
        wr(8'hDB, 8'h7F); wr(8'hDD, 8'h01);              // ext2 only
        accept(6, 16'h7777, 8'h04, 8'h50, 1, 0);          // key-scan arrives mid-run
        rd(8'hDD, d); chk(d == 8'h40, "R10 late request left pending", d, 8'h40);
        clear_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_periph();
        t_edges();
        t_gate();
        t_prio();
        t_coinc();
        t_busy();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule